// File: doc/BRIEF.md
# SD Card Single-Block Data Mover

This engine moves one data block between a local byte buffer and an SD card over SPI. The command that opens the transfer must already have been accepted before the engine starts. The engine does not drive the serial wires itself. It hands one byte at a time to an SPI byte-exchange port, waits for the byte the card returned, and controls the card's chip select. A pulse on `start` samples `wr_mode` and `blk_len` and begins the transfer. When the transfer is finished, `done` pulses for one cycle and `err` shows whether it failed.

In read mode the engine clocks idle bytes (0xFF) until the card returns the start token 0xFE. It then writes the next `blk_len` bytes into the buffer in order, and clocks two further bytes that it discards as the CRC. In write mode it sends 0xFE, then `blk_len` bytes fetched from the buffer, then two 0xFF bytes in place of the CRC. It then reads the card's data response token. If the card accepted the block, the engine keeps clocking 0xFF for as long as the card returns 0x00, which means the card is busy. The block length is programmable, so the same engine can move a 512-byte sector or a 16-byte register block.

The states are IDLE, HUNT, RD_DATA, RD_CRC, WR_TOK, WR_DATA, WR_CRC, WR_RESP, WR_BUSY, TAIL and DONE. Each transition between them is listed below.

- IDLE to HUNT or WR_TOK: on `start`, with the target chosen by `wr_mode`.
- HUNT to RD_DATA: when 0xFE is received.
- HUNT to TAIL: when the hunt limit expires.
- RD_DATA to RD_CRC: after the last payload byte.
- RD_CRC to TAIL: after the second CRC byte.
- WR_TOK to WR_DATA: after the token is sent.
- WR_DATA to WR_CRC: after the last payload byte.
- WR_CRC to WR_RESP: after the second dummy CRC byte.
- WR_RESP to WR_BUSY: when the card accepts the block.
- WR_RESP to TAIL: when the card rejects the block.
- WR_BUSY to TAIL: on the first non-zero byte, or when the busy limit expires.
- TAIL to DONE: after the closing byte.
- DONE to IDLE: always, one cycle later.

Top module: `sd_blk_xfer`

## Requirements
- R1: After reset, `cs_n` is high, `xch_go` is low, `done` is low and `buf_we` is low.
- R2: In read mode the engine holds `cs_n` low and sends 0xFF on every exchange until a received byte equals 0xFE. The 0xFE byte is not written to the buffer.
- R3: After the start token, the next `blk_len` received bytes are written to buffer addresses 0 to `blk_len`-1 in arrival order. Two more 0xFF exchanges then follow with `cs_n` low, and neither of them writes to the buffer.
- R4: In write mode the engine sends, with `cs_n` low, the sequence 0xFE, then the buffer bytes at addresses 0 to `blk_len`-1 in order, then 0xFF and 0xFF.
- R5: After the write CRC, one 0xFF exchange returns the response token. If bits [4:0] of that byte equal 5'b00101, the block is accepted. Any other value (for example 0x0B for a CRC error or 0x0D for a write error) sets `err` and skips the busy wait.
- R6: After an accepted block, the engine sends 0xFF for as long as the received byte is 0x00. The first non-zero byte ends the wait without an error.
- R7: Every transfer ends with exactly one 0xFF exchange made with `cs_n` high. After it, `done` is high for exactly one cycle, and `err` holds the outcome from then until the next start.
- R8: If HUNT_LIMIT successive bytes arrive without a start token, the engine stops hunting, writes nothing to the buffer, sets `err` and goes to the closing exchange.
- R9: If BUSY_LIMIT successive 0x00 bytes arrive during the busy wait, the engine sets `err` and goes to the closing exchange.
- R10: The block length comes from `blk_len` sampled at start, in the range 1 to 2^LEN_W-1. Both 16 and 512 transfer correctly.
- R11: A `start` pulse that arrives while a transfer is in progress has no effect on that transfer's byte sequence or outcome.
- R12: At most one exchange is outstanding at any time. `xch_go` is raised only after the previous exchange has completed with `xch_done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a transfer; honoured only when idle |
| wr_mode | input | 1 | 1 selects write, 0 selects read; sampled with start |
| blk_len | input | LEN_W | Payload byte count; sampled with start |
| done | output | 1 | One-cycle pulse at the end of a transfer |
| err | output | 1 | Outcome of the last transfer, 1 on failure |
| cs_n | output | 1 | Card chip select, active low |
| xch_go | output | 1 | Request one byte exchange |
| xch_tx | output | 8 | Byte to send, valid with xch_go |
| xch_done | input | 1 | Exchange complete, xch_rx valid |
| xch_rx | input | 8 | Byte received from the card |
| buf_addr | output | LEN_W | Buffer byte address |
| buf_we | output | 1 | Buffer write strobe |
| buf_wdata | output | 8 | Byte to write into the buffer |
| buf_rdata | input | 8 | Buffer read data, one cycle after buf_addr |

## Verification
The assertions assume three things about the exchange port and the buffer. First, the port raises `xch_done` for exactly one cycle per request, and never while no request is outstanding. Second, it takes at least one cycle to answer. Third, buffer read data follows the address with one cycle of latency. The bench's port model answers each `xch_go` exactly once, three cycles later, and only ever answers a single pending request. Its buffer model refreshes the read data from the current address every cycle. Response, busy and filler bytes come from a queue built for each test, so the card never produces a byte outside the patterns the requirements describe.

// File: rtl/sd_xfer_pkg.sv
package sd_xfer_pkg;

    typedef enum logic [3:0] {
        S_IDLE,
        S_HUNT,
        S_RD_DATA,
        S_RD_CRC,
        S_WR_TOK,
        S_WR_DATA,
        S_WR_CRC,
        S_WR_RESP,
        S_WR_BUSY,
        S_TAIL,
        S_DONE
    } xfer_state_t;

    localparam logic [7:0] BYTE_START = 8'hFE;
    localparam logic [7:0] BYTE_IDLE  = 8'hFF;
    localparam logic [4:0] RESP_OK    = 5'b00101;

endpackage

// File: rtl/sd_xfer_wdog.sv
module sd_xfer_wdog #(
    parameter int LIMIT = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic step,
    output logic expired
);
    localparam int CW = $clog2(LIMIT + 1);

    logic [CW-1:0] cnt_q;

    assign expired = (cnt_q == CW'(LIMIT - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clr) begin
            cnt_q <= '0;
        end else if (step) begin
            cnt_q <= cnt_q + CW'(1);
        end
    end

endmodule

// File: rtl/sd_blk_xfer.sv
module sd_blk_xfer
    import sd_xfer_pkg::*;
#(
    parameter int LEN_W      = 10,
    parameter int HUNT_LIMIT = 64,
    parameter int BUSY_LIMIT = 4096
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             wr_mode,
    input  logic [LEN_W-1:0] blk_len,
    output logic             done,
    output logic             err,
    output logic             cs_n,
    output logic             xch_go,
    output logic [7:0]       xch_tx,
    input  logic             xch_done,
    input  logic [7:0]       xch_rx,
    output logic [LEN_W-1:0] buf_addr,
    output logic             buf_we,
    output logic [7:0]       buf_wdata,
    input  logic [7:0]       buf_rdata
);

    xfer_state_t      state_q, state_d;
    logic             pend_q;
    logic [LEN_W-1:0] cnt_q;
    logic [LEN_W-1:0] len_q;
    logic [LEN_W-1:0] addr_q;
    logic             err_q;
    logic             cs_q;
    logic             we_q;
    logic [7:0]       wdata_q;
    logic             fail_now;
    logic             issue;
    logic             got;
    logic             last_pay;
    logic             hunt_exp;
    logic             busy_exp;
    logic             launch;

    assign launch   = (state_q == S_IDLE) && start;
    assign issue    = (state_q != S_IDLE) && (state_q != S_DONE) && !pend_q;
    assign got      = xch_done && pend_q;
    assign last_pay = (cnt_q == len_q - LEN_W'(1));

    sd_xfer_wdog #(.LIMIT(HUNT_LIMIT)) u_hunt_wdog (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (state_q == S_IDLE),
        .step    (got && (state_q == S_HUNT) && (xch_rx != BYTE_START)),
        .expired (hunt_exp)
    );

    sd_xfer_wdog #(.LIMIT(BUSY_LIMIT)) u_busy_wdog (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (state_q == S_IDLE),
        .step    (got && (state_q == S_WR_BUSY) && (xch_rx == 8'h00)),
        .expired (busy_exp)
    );

    // next-state logic
    always_comb begin
        state_d  = state_q;
        fail_now = 1'b0;
        unique case (state_q)
            S_IDLE:    if (start) state_d = wr_mode ? S_WR_TOK : S_HUNT;
            S_HUNT:
                if (got) begin
                    if (xch_rx == BYTE_START) begin
                        state_d = S_RD_DATA;
                    end else if (hunt_exp) begin
                        state_d  = S_TAIL;
                        fail_now = 1'b1;
                    end
                end
            S_RD_DATA: if (got && last_pay) state_d = S_RD_CRC;
            S_RD_CRC:  if (got && cnt_q[0]) state_d = S_TAIL;
            S_WR_TOK:  if (got) state_d = S_WR_DATA;
            S_WR_DATA: if (got && last_pay) state_d = S_WR_CRC;
            S_WR_CRC:  if (got && cnt_q[0]) state_d = S_WR_RESP;
            S_WR_RESP:
                if (got) begin
                    if (xch_rx[4:0] == RESP_OK) begin
                        state_d = S_WR_BUSY;
                    end else begin
                        state_d  = S_TAIL;
                        fail_now = 1'b1;
                    end
                end
            S_WR_BUSY:
                if (got) begin
                    if (xch_rx != 8'h00) begin
                        state_d = S_TAIL;
                    end else if (busy_exp) begin
                        state_d  = S_TAIL;
                        fail_now = 1'b1;
                    end
                end
            S_TAIL:    if (got) state_d = S_DONE;
            S_DONE:    state_d = S_IDLE;
            default:   state_d = S_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // outputs and datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_q  <= 1'b0;
            cnt_q   <= '0;
            len_q   <= '0;
            addr_q  <= '0;
            err_q   <= 1'b0;
            cs_q    <= 1'b1;
            we_q    <= 1'b0;
            wdata_q <= '0;
        end else begin
            if (issue)         pend_q <= 1'b1;
            else if (xch_done) pend_q <= 1'b0;

            if (state_d != state_q) begin
                cnt_q <= '0;
            end else if (got && (state_q == S_RD_DATA || state_q == S_RD_CRC ||
                                 state_q == S_WR_DATA || state_q == S_WR_CRC)) begin
                cnt_q <= cnt_q + LEN_W'(1);
            end

            we_q    <= got && (state_q == S_RD_DATA);
            wdata_q <= xch_rx;

            if (launch) begin
                len_q  <= blk_len;
                addr_q <= '0;
                err_q  <= 1'b0;
                cs_q   <= 1'b0;
            end else begin
                if (we_q || (issue && state_q == S_WR_DATA)) addr_q <= addr_q + LEN_W'(1);
                if (fail_now) err_q <= 1'b1;
                if (state_d == S_TAIL) cs_q <= 1'b1;
            end
        end
    end

    always_comb begin
        unique case (state_q)
            S_WR_TOK:  xch_tx = BYTE_START;
            S_WR_DATA: xch_tx = buf_rdata;
            default:   xch_tx = BYTE_IDLE;
        endcase
    end

    assign xch_go    = issue;
    assign cs_n      = cs_q;
    assign done      = (state_q == S_DONE);
    assign err       = err_q;
    assign buf_addr  = addr_q;
    assign buf_we    = we_q;
    assign buf_wdata = wdata_q;

endmodule

// File: rtl/sd_blk_xfer_chk.sv
module sd_blk_xfer_chk (
    input logic clk,
    input logic rst_n,
    input logic done,
    input logic cs_n,
    input logic xch_go,
    input logic xch_done,
    input logic buf_we
);
    logic open_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        open_q <= 1'b0;
        else if (xch_go)   open_q <= 1'b1;
        else if (xch_done) open_q <= 1'b0;
    end

    a_r12_one_outstanding: assert property (@(posedge clk) disable iff (!rst_n)
        xch_go |-> !open_q);

    a_r7_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r7_done_cs_high: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> cs_n);

    a_r7_no_go_on_done: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !xch_go);

    a_r3_write_in_frame: assert property (@(posedge clk) disable iff (!rst_n)
        buf_we |-> !cs_n);

endmodule

bind sd_blk_xfer sd_blk_xfer_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .done     (done),
    .cs_n     (cs_n),
    .xch_go   (xch_go),
    .xch_done (xch_done),
    .buf_we   (buf_we)
);

// File: tb/sd_blk_xfer_tb.sv
module sd_blk_xfer_tb;
    localparam int LEN_W = 10;
    localparam int HL    = 8;
    localparam int BL    = 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic wr_mode = 1'b0;
    logic [LEN_W-1:0] blk_len = '0;
    logic done, err, cs_n, xch_go, buf_we;
    logic [7:0] xch_tx, buf_wdata;
    logic xch_done = 1'b0;
    logic [7:0] xch_rx = 8'hFF;
    logic [LEN_W-1:0] buf_addr;
    logic [7:0] buf_rdata = 8'h00;

    always #4 clk = ~clk;

    sd_blk_xfer #(.LEN_W(LEN_W), .HUNT_LIMIT(HL), .BUSY_LIMIT(BL)) u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .wr_mode(wr_mode), .blk_len(blk_len),
        .done(done), .err(err), .cs_n(cs_n), .xch_go(xch_go), .xch_tx(xch_tx),
        .xch_done(xch_done), .xch_rx(xch_rx), .buf_addr(buf_addr), .buf_we(buf_we),
        .buf_wdata(buf_wdata), .buf_rdata(buf_rdata)
    );

    int checks = 0;
    int fails = 0;
    string cur_req = "R1";
    logic [7:0] mem [0:1023];
    logic [7:0] rx_q [$];
    logic [7:0] exp_tx [$];
    logic       exp_cs [$];
    int         exp_wa [$];
    logic [7:0] exp_wd [$];
    int lat = 0;
    bit finished = 0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // reference model of the exchange port, buffer and expected traffic
    always @(negedge clk) begin
        xch_done = 1'b0;
        buf_rdata = mem[buf_addr];
        if (rst_n) begin
            if (lat > 0) begin
                lat--;
                if (lat == 0) begin
                    xch_done = 1'b1;
                    xch_rx = (rx_q.size() > 0) ? rx_q.pop_front() : 8'hFF;
                end
            end
            if (xch_go) begin
                chk(lat == 0, "R12", lat, 0);
                if (exp_tx.size() == 0) begin
                    chk(0, {cur_req, " extra exchange"}, xch_tx, 0);
                end else begin
                    logic [7:0] et;
                    logic ec;
                    et = exp_tx.pop_front();
                    ec = exp_cs.pop_front();
                    chk(xch_tx == et, {cur_req, " tx"}, xch_tx, et);
                    chk(cs_n == ec, {cur_req, " cs_n"}, cs_n, ec);
                end
                lat = 3;
            end
            if (buf_we) begin
                if (exp_wa.size() == 0) begin
                    chk(0, {cur_req, " unexpected buffer write"}, buf_addr, 0);
                end else begin
                    int ea;
                    logic [7:0] ed;
                    ea = exp_wa.pop_front();
                    ed = exp_wd.pop_front();
                    chk(int'(buf_addr) == ea && buf_wdata == ed, {cur_req, " R3 write"},
                        {buf_addr, buf_wdata}, {ea[LEN_W-1:0], ed});
                end
            end
        end
    end

    task automatic expect_x(input logic [7:0] b, input logic c);
        exp_tx.push_back(b);
        exp_cs.push_back(c);
    endtask

    task automatic kick(input bit w, input int len);
        @(negedge clk);
        wr_mode = w;
        blk_len = LEN_W'(len);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic finish_xfer(input bit exp_err, input bit mid_start);
        int n = 0;
        bit seen = 0;
        while (n < 30000) begin
            @(negedge clk);
            n++;
            if (mid_start && n == 40) begin
                start = 1'b1;
                wr_mode = ~wr_mode;
                blk_len = LEN_W'(3);
            end else begin
                start = 1'b0;
            end
            if (done) begin
                seen = 1;
                break;
            end
        end
        chk(seen, {cur_req, " R7 done seen"}, seen, 1);
        chk(err == exp_err, {cur_req, " R7 err"}, err, exp_err);
        chk(exp_tx.size() == 0, {cur_req, " exchanges left"}, exp_tx.size(), 0);
        chk(exp_wa.size() == 0, {cur_req, " writes left"}, exp_wa.size(), 0);
        @(negedge clk);
        chk(!done, "R7 done one cycle", done, 0);
        chk(err == exp_err, "R7 err held", err, exp_err);
    endtask

    // read: fill non-token bytes, optional token
    task automatic do_read(input string req, input int fill, input int len, input bit tok, input bit mid);
        cur_req = req;
        for (int i = 0; i < fill; i++) rx_q.push_back((i % 2) ? 8'h7E : 8'hFF);
        if (tok) begin
            rx_q.push_back(8'hFE);
            for (int i = 0; i < fill + 1; i++) expect_x(8'hFF, 1'b0);
            for (int i = 0; i < len; i++) begin
                logic [7:0] d;
                d = 8'((i * 37 + fill) ^ (i >> 3));
                rx_q.push_back(d);
                exp_wa.push_back(i);
                exp_wd.push_back(d);
                expect_x(8'hFF, 1'b0);
            end
            rx_q.push_back(8'hA5);
            rx_q.push_back(8'h5A);
            expect_x(8'hFF, 1'b0);
            expect_x(8'hFF, 1'b0);
        end else begin
            for (int i = 0; i < HL; i++) expect_x(8'hFF, 1'b0);
        end
        expect_x(8'hFF, 1'b1);
        kick(1'b0, len);
        finish_xfer(!tok, mid);
        rx_q.delete();
    endtask

    // write: resp token, zeros before ready (>= BL means timeout)
    task automatic do_write(input string req, input int len, input logic [7:0] resp, input int zeros, input bit mid);
        bit ok;
        bit fail;
        cur_req = req;
        ok = (resp[4:0] == 5'b00101);
        for (int i = 0; i < len; i++) mem[i] = 8'((i * 11 + len) ^ 8'h3C);
        expect_x(8'hFE, 1'b0);
        for (int i = 0; i < len; i++) expect_x(mem[i], 1'b0);
        expect_x(8'hFF, 1'b0);
        expect_x(8'hFF, 1'b0);
        expect_x(8'hFF, 1'b0);
        for (int i = 0; i < len + 3; i++) rx_q.push_back(8'hFF);
        rx_q.push_back(resp);
        fail = !ok;
        if (ok) begin
            if (zeros >= BL) begin
                for (int i = 0; i < BL; i++) begin
                    rx_q.push_back(8'h00);
                    expect_x(8'hFF, 1'b0);
                end
                fail = 1;
            end else begin
                for (int i = 0; i < zeros; i++) begin
                    rx_q.push_back(8'h00);
                    expect_x(8'hFF, 1'b0);
                end
                rx_q.push_back(8'h01);
                expect_x(8'hFF, 1'b0);
            end
        end
        expect_x(8'hFF, 1'b1);
        kick(1'b1, len);
        finish_xfer(fail, mid);
        rx_q.delete();
    endtask

    initial begin
        for (int i = 0; i < 1024; i++) mem[i] = 8'h00;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(cs_n == 1'b1, "R1 cs_n", cs_n, 1);
        chk(xch_go == 1'b0, "R1 go", xch_go, 0);
        chk(done == 1'b0, "R1 done", done, 0);
        chk(buf_we == 1'b0, "R1 we", buf_we, 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk(cs_n == 1'b1 && xch_go == 1'b0, "R1 idle after reset", {cs_n, xch_go}, 2);

        do_read("R2 R10 read16 hunt", 3, 16, 1'b1, 1'b0);
        do_read("R3 read immediate token", 0, 5, 1'b1, 1'b0);
        do_read("R10 read512", 1, 512, 1'b1, 1'b0);
        do_read("R8 hunt limit", 0, 16, 1'b0, 1'b0);
        do_read("R2 hunt just under limit", HL - 1, 4, 1'b1, 1'b0);
        do_write("R4 R6 write16 busy", 16, 8'hE5, 3, 1'b0);
        do_write("R5 crc reject", 16, 8'h0B, 0, 1'b0);
        do_write("R5 write reject", 8, 8'h0D, 0, 1'b0);
        do_write("R6 ready at once", 1, 8'h05, 0, 1'b0);
        do_write("R9 busy limit", 4, 8'h25, BL, 1'b0);
        do_write("R6 busy just under limit", 4, 8'h05, BL - 1, 1'b0);
        do_write("R10 write512", 512, 8'h05, 2, 1'b0);
        do_write("R11 start during write", 64, 8'h05, 1, 1'b1);
        do_read("R11 start during read", 2, 64, 1'b1, 1'b1);

        if (!finished) begin
            finished = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            fails++;
            checks++;
            $display("FAIL watchdog R7 actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule